// File: doc/BRIEF.md
# Column PWM Exposure Sequencer

This block times one row of pulse-width gray-scale for a bank of column channels in a passive-matrix emissive panel. Each channel gets three enables: one that connects the channel to the precharge voltage, one that turns on its current source, and one that ties it to ground. A rising edge on the row latch input starts a row. The block captures every column's 6-bit code and the row configuration at that edge. It then runs an optional precharge interval, an exposure window in which each channel conducts for as many exposure ticks as its code says, and a shorting phase.

The exposure clock reaches the block as a one-cycle tick that is synchronous to the system clock. Exposure takes 64 ticks. The counter then stops, so extra ticks before the next row change nothing. Shorting has two modes. In the first, every channel is grounded together once the count reaches 64. In the second, each channel is grounded as soon as its own exposure ends. A run bit of 0 holds the block in low-power standby. The run bit's registered copy is 0 after reset.

Top module: `col_pwm_seq`

## Requirements
- R1: During and after synchronous reset, every enable output is 0 and the block is in standby (the run flag is 0) until `op_en` has been sampled high.
- R2: A row starts only on a 0-to-1 transition of `row_le` that is sampled while running. Holding `row_le` high does not start further rows.
- R3: After a row start with `pre_off`=0 and `pre_len`=N (N from 1 to 7), `prech_en` is all ones for exactly N exposure ticks. `cur_en` stays 0 during this interval.
- R4: With `pre_off`=1 or `pre_len`=0, no precharge happens and exposure begins in the cycle right after the row start.
- R5: Exposure counting starts with the first tick after precharge ends. Channel i conducts (`cur_en[i]`=1) for exactly the number of ticks given by its code, bits [6i+5:6i] of `col_code`.
- R6: A channel whose code is 0 never asserts `cur_en` in that row.
- R7: The exposure count stops at 64. Ticks after the 64th and before the next row start leave all outputs unchanged.
- R8: With `short_all`=1 captured at the row start, `short_en` is 0 during exposure and becomes all ones together after the 64th exposure tick.
- R9: With `short_all`=0 captured, `short_en[i]` goes to 1 in the first cycle that channel i is in exposure and no longer conducting, and stays 1 to the end of the row.
- R10: For every channel, at most one of `prech_en`, `cur_en` and `short_en` is 1 in any cycle.
- R11: While the registered run flag is 0, all enables are 0 and `row_le` edges are ignored. Dropping `op_en` in the middle of a row cancels that row.
- R12: Codes, `pre_len`, `pre_off` and `short_all` are captured only at a row start. Changing them later in the row has no effect on that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Run bit; 0 selects standby |
| row_le | input | 1 | Row latch; its rising edge starts a row |
| exp_tick | input | 1 | One-cycle exposure clock tick |
| pre_len | input | PRE_W (3) | Precharge length in exposure ticks |
| pre_off | input | 1 | 1 skips precharge |
| short_all | input | 1 | 1 = global short at count 64, 0 = per-channel short |
| col_code | input | NCOL*CODE_W (48) | Per-column exposure codes, channel i in bits [6i+5:6i] |
| prech_en | output | NCOL (8) | Per-channel precharge enable |
| cur_en | output | NCOL (8) | Per-channel current-source enable |
| short_en | output | NCOL (8) | Per-channel short-to-ground enable |

## Verification
The bench checks the code boundaries 0 and 63. A design off by one here would light a code-0 channel for one tick, or never end a code-63 channel before the global short. It checks precharge lengths of 0 and 7 and the disable bit, which together catch a design that counts one tick too many or that skips the first exposure tick. It sends long runs of ticks past 64 to expose a counter that wraps and relights channels. It holds the latch high, drops the run bit in the middle of a row, and changes inputs during a row, which would show a design that restarts on a level, keeps driving in standby, or reads its configuration live instead of from the copy taken at the row start.

// File: rtl/col_pwm_pkg.sv
`timescale 1ns/1ps
package col_pwm_pkg;

    // Row phase shared by the sequencer and every channel slice.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_EXPO = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    // Control bundle produced by one channel slice.
    typedef struct packed {
        logic pre;
        logic cur;
        logic sh;
    } chan_ctl_t;

    // Number of exposure ticks in a full row for a code width.
    function automatic int unsigned expo_len(input int unsigned code_w);
        return 32'd1 << code_w;
    endfunction

endpackage

// File: rtl/pwm_phase_ctrl.sv
`timescale 1ns/1ps
module pwm_phase_ctrl
    import col_pwm_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int PRE_W  = 3,
    localparam int FULL  = expo_len(CODE_W),
    localparam int CNT_W = CODE_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_en,
    input  logic             le,
    input  logic             tick,
    input  logic [PRE_W-1:0] pre_len,
    input  logic             pre_off,
    input  logic             short_all,
    output logic             load,
    output logic             run,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output logic             sa
);

    logic             run_q;
    logic             le_q;
    phase_e           ph_q;
    logic [PRE_W-1:0] pc_q;
    logic [PRE_W-1:0] plen_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sa_q;
    logic             le_edge;

    assign le_edge = le & ~le_q & run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            le_q   <= 1'b0;
            ph_q   <= PH_IDLE;
            pc_q   <= '0;
            plen_q <= '0;
            cnt_q  <= '0;
            sa_q   <= 1'b0;
        end else begin
            run_q <= op_en;
            le_q  <= le;
            if (!run_q) begin
                ph_q  <= PH_IDLE;
                pc_q  <= '0;
                cnt_q <= '0;
            end else if (le_edge) begin
                plen_q <= pre_len;
                sa_q   <= short_all;
                pc_q   <= '0;
                cnt_q  <= '0;
                ph_q   <= (pre_off || pre_len == '0) ? PH_EXPO : PH_PRE;
            end else if (tick) begin
                case (ph_q)
                    PH_PRE: begin
                        pc_q <= pc_q + PRE_W'(1);
                        if (pc_q + PRE_W'(1) == plen_q) ph_q <= PH_EXPO;
                    end
                    PH_EXPO: begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(FULL - 1)) ph_q <= PH_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign load  = le_edge;
    assign run   = run_q;
    assign phase = ph_q;
    assign cnt   = cnt_q;
    assign sa    = sa_q;

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(FULL));

    // R3
    pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_PRE) |-> (pc_q < plen_q));

    // R11
    standby_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> (ph_q == PH_IDLE));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DONE && run_q && !le_edge) |=> (ph_q == PH_DONE || !run_q));

endmodule

// File: rtl/pwm_chan_slice.sv
`timescale 1ns/1ps
module pwm_chan_slice
    import col_pwm_pkg::*;
#(
    parameter int CODE_W = 6,
    localparam int CNT_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic              run,
    input  phase_e            phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              sa,
    output chan_ctl_t         ctl
);

    logic [CODE_W-1:0] code_q;
    logic              lit;
    logic              in_row;

    always_ff @(posedge clk) begin
        if (rst)       code_q <= '0;
        else if (load) code_q <= code_in;
    end

    assign lit    = (cnt < {1'b0, code_q});
    assign in_row = (phase == PH_EXPO) || (phase == PH_DONE);

    always_comb begin
        ctl.pre = run && (phase == PH_PRE);
        ctl.cur = run && (phase == PH_EXPO) && lit;
        ctl.sh  = run && (sa ? (phase == PH_DONE) : (in_row && !lit));
    end

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pre, ctl.cur, ctl.sh}));

    // R6
    zero_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (code_q == '0) |-> !ctl.cur);

    // R9
    short_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.sh && !sa && !load && run && $past(run)) |=> (ctl.sh || !run || phase == PH_IDLE));

endmodule

// File: rtl/col_pwm_seq.sv
`timescale 1ns/1ps
module col_pwm_seq
    import col_pwm_pkg::*;
#(
    parameter int NCOL   = 8,
    parameter int CODE_W = 6,
    parameter int PRE_W  = 3,
    localparam int CNT_W = CODE_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   op_en,
    input  logic                   row_le,
    input  logic                   exp_tick,
    input  logic [PRE_W-1:0]       pre_len,
    input  logic                   pre_off,
    input  logic                   short_all,
    input  logic [NCOL*CODE_W-1:0] col_code,
    output logic [NCOL-1:0]        prech_en,
    output logic [NCOL-1:0]        cur_en,
    output logic [NCOL-1:0]        short_en
);

    logic             load;
    logic             run;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             sa;

    pwm_phase_ctrl #(
        .CODE_W (CODE_W),
        .PRE_W  (PRE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op_en     (op_en),
        .le        (row_le),
        .tick      (exp_tick),
        .pre_len   (pre_len),
        .pre_off   (pre_off),
        .short_all (short_all),
        .load      (load),
        .run       (run),
        .phase     (phase),
        .cnt       (cnt),
        .sa        (sa)
    );

    for (genvar g = 0; g < NCOL; g++) begin : g_chan
        chan_ctl_t ctl;
        pwm_chan_slice #(
            .CODE_W (CODE_W)
        ) u_slice (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .code_in (col_code[g*CODE_W +: CODE_W]),
            .run     (run),
            .phase   (phase),
            .cnt     (cnt),
            .sa      (sa),
            .ctl     (ctl)
        );
        assign prech_en[g] = ctl.pre;
        assign cur_en[g]   = ctl.cur;
        assign short_en[g] = ctl.sh;
    end

    // R7
    sat_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE && run && op_en && !load) |=> ($stable(cur_en) && $stable(short_en)));

    // R11
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> (prech_en == '0 && cur_en == '0 && short_en == '0));

    // R3
    pre_no_cur_chk: assert property (@(posedge clk) disable iff (rst)
        (prech_en != '0) |-> (cur_en == '0));

endmodule

// File: tb/col_pwm_seq_test.sv
`timescale 1ns/1ps
module col_pwm_seq_test;

    localparam int N    = 8;
    localparam int CW   = 6;
    localparam int PW   = 3;
    localparam int FULL = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst = 1'b1;
    logic            op_en = 1'b0;
    logic            row_le = 1'b0;
    logic            exp_tick = 1'b0;
    logic [PW-1:0]   pre_len = '0;
    logic            pre_off = 1'b0;
    logic            short_all = 1'b0;
    logic [N*CW-1:0] col_code = '0;
    wire  [N-1:0]    prech_en;
    wire  [N-1:0]    cur_en;
    wire  [N-1:0]    short_en;

    col_pwm_seq #(.NCOL(N), .CODE_W(CW), .PRE_W(PW)) uut (
        .clk(clk), .rst(rst), .op_en(op_en), .row_le(row_le), .exp_tick(exp_tick),
        .pre_len(pre_len), .pre_off(pre_off), .short_all(short_all),
        .col_code(col_code), .prech_en(prech_en), .cur_en(cur_en), .short_en(short_en)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Reference model state, built from the requirements
    bit m_run, m_leq, m_sa;
    int m_ph, m_pc, m_plen, m_cnt;
    int m_code [N];

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        bit edge_ok;
        if (rst) begin
            m_run = 0; m_leq = 0; m_sa = 0; m_ph = 0; m_pc = 0; m_plen = 0; m_cnt = 0;
            for (int i = 0; i < N; i++) m_code[i] = 0;
        end else begin
            edge_ok = row_le && !m_leq && m_run;
            if (!m_run) begin
                m_ph = 0; m_cnt = 0; m_pc = 0;
            end else if (edge_ok) begin
                for (int i = 0; i < N; i++) m_code[i] = int'(col_code[i*CW +: CW]);
                m_plen = int'(pre_len); m_sa = short_all; m_cnt = 0; m_pc = 0;
                m_ph = (pre_off || pre_len == 0) ? 2 : 1;
            end else if (exp_tick) begin
                if (m_ph == 1) begin
                    m_pc++;
                    if (m_pc == m_plen) m_ph = 2;
                end else if (m_ph == 2) begin
                    m_cnt++;
                    if (m_cnt == FULL) m_ph = 3;
                end
            end
            m_run = op_en;
            m_leq = row_le;
        end
    endtask

    task automatic cyc();
        logic [N-1:0] e_pre, e_cur, e_sh;
        string tag;
        @(posedge clk);
        model_step();
        #1;
        for (int i = 0; i < N; i++) begin
            e_pre[i] = m_run && m_ph == 1;
            e_cur[i] = m_run && m_ph == 2 && m_cnt < m_code[i];
            e_sh[i]  = m_run && (m_sa ? (m_ph == 3)
                                      : ((m_ph == 2 || m_ph == 3) && m_cnt >= m_code[i]));
        end
        tag = !m_run ? "R11" : (m_ph == 0 ? "R2" : (m_ph == 1 ? "R3" : "R5"));
        check(tag, "prech_en", prech_en, e_pre);
        check(m_ph == 1 ? "R3" : tag, "cur_en", cur_en, e_cur);
        check(m_sa ? "R8" : "R9", "short_en", short_en, e_sh);
        check("R10", "overlap", (prech_en & cur_en) | (prech_en & short_en) | (cur_en & short_en), '0);
        for (int i = 0; i < N; i++)
            if (m_ph != 0 && m_code[i] == 0 && cur_en[i] !== 1'b0) begin
                checks++; fails++;
                $display("FAIL R6 code-zero channel %0d actual=1 expected=0", i);
            end
    endtask

    function automatic logic [N*CW-1:0] rand_codes();
        logic [N*CW-1:0] v;
        for (int i = 0; i < N; i++) begin
            case ($urandom_range(0, 5))
                0:       v[i*CW +: CW] = '0;
                1:       v[i*CW +: CW] = 6'd63;
                default: v[i*CW +: CW] = CW'($urandom_range(0, 63));
            endcase
        end
        return v;
    endfunction

    // Run one row: latch pulse, ticks until exposure done, then extra ticks.
    task automatic run_row(input logic [N*CW-1:0] codes, input int plen, input bit poff,
                           input bit sa, input int tick_pct, input int extra, input bit mess);
        int guard;
        col_code = codes; pre_len = PW'(plen); pre_off = poff; short_all = sa;
        exp_tick = 1'b0; row_le = 1'b1;
        cyc();
        row_le = 1'b0;
        if (mess) begin
            // R12: reprogram everything after the row has started
            col_code = ~codes; pre_len = PW'(7 - plen); pre_off = ~poff; short_all = ~sa;
        end
        guard = 0;
        while (m_ph != 3 && guard < 3000) begin
            exp_tick = ($urandom_range(0, 99) < tick_pct);
            cyc();
            guard++;
        end
        exp_tick = 1'b0;
        for (int k = 0; k < extra; k++) begin
            exp_tick = ~exp_tick;
            cyc();
        end
        exp_tick = 1'b0;
    endtask

    initial begin
        logic [N-1:0] snap_cur, snap_sh;
        void'($urandom(32'd20417));

        // R1: reset state
        rst = 1'b1;
        cyc(); cyc();
        check("R1", "prech_en in reset", prech_en, '0);
        check("R1", "cur_en in reset", cur_en, '0);
        check("R1", "short_en in reset", short_en, '0);
        rst = 1'b0;

        // R11: standby ignores the latch
        op_en = 1'b0;
        col_code = {N{6'd20}};
        row_le = 1'b1; cyc(); row_le = 1'b0;
        for (int k = 0; k < 6; k++) begin exp_tick = 1'b1; cyc(); end
        exp_tick = 1'b0;
        check("R11", "cur_en after standby latch", cur_en, '0);
        check("R11", "short_en after standby latch", short_en, '0);

        op_en = 1'b1; cyc(); cyc();

        // R4: precharge disabled, exposure begins at once
        col_code = {N{6'd5}}; pre_len = 3'd5; pre_off = 1'b1; short_all = 1'b0;
        row_le = 1'b1; cyc(); row_le = 1'b0;
        check("R4", "no precharge when disabled", prech_en, '0);
        check("R4", "exposure right after start", cur_en, '1);
        run_row({N{6'd0}}, 0, 0, 1, 100, 0, 0);
        check("R4", "zero length precharge skipped", prech_en, '0);

        // R3 boundary: longest precharge, full codes
        run_row({N{6'd63}}, 7, 0, 1, 100, 4, 0);
        check("R8", "global short after row", short_en, '1);

        // R7: many extra ticks leave outputs unchanged
        run_row(rand_codes(), 2, 0, 0, 60, 0, 0);
        snap_cur = cur_en; snap_sh = short_en;
        for (int k = 0; k < 40; k++) begin exp_tick = 1'b1; cyc(); end
        exp_tick = 1'b0;
        check("R7", "cur_en after surplus ticks", cur_en, snap_cur);
        check("R7", "short_en after surplus ticks", short_en, snap_sh);

        // R2: latch held high does not restart a row
        run_row(rand_codes(), 1, 0, 1, 100, 0, 0);
        row_le = 1'b1; cyc();
        row_le = 1'b1;
        for (int k = 0; k < 5; k++) begin exp_tick = 1'b1; cyc(); end
        for (int k = 0; k < 90; k++) begin exp_tick = 1'b1; cyc(); end
        snap_sh = short_en;
        for (int k = 0; k < 10; k++) cyc();
        check("R2", "held latch keeps finished row", short_en, snap_sh);
        row_le = 1'b0; exp_tick = 1'b0; cyc();

        // R12: mid-row reprogramming ignored
        run_row(rand_codes(), 3, 0, 0, 50, 3, 1);
        run_row(rand_codes(), 6, 0, 1, 40, 3, 1);

        // R11: standby drop mid-row cancels it
        col_code = rand_codes(); pre_len = 3'd1; pre_off = 1'b0; short_all = 1'b0;
        row_le = 1'b1; cyc(); row_le = 1'b0;
        for (int k = 0; k < 10; k++) begin exp_tick = 1'b1; cyc(); end
        op_en = 1'b0; cyc(); cyc();
        check("R11", "row cancelled by standby", cur_en | short_en | prech_en, '0);
        op_en = 1'b1; cyc(); cyc();
        check("R11", "no restart after standby", cur_en | short_en | prech_en, '0);

        // Random rows (R5, R9, R8, R3)
        for (int r = 0; r < 30; r++)
            run_row(rand_codes(), $urandom_range(0, 7), ($urandom_range(0, 4) == 0),
                    $urandom_range(0, 1), $urandom_range(25, 100), $urandom_range(0, 8),
                    $urandom_range(0, 1));

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1999000;
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule